// File: doc/BRIEF.md
# Printer Port Register Interface

This block is the host side of a byte-wide printer port, reached through a small register bus with separate write and read enables. It holds a data register (one copy for bytes written by the host, one copy latched from the port pins), a status register and a control register. It also acts out the printer handshake itself. Raising the strobe bit in the control register hands the written byte to a downstream printer model as a one-cycle stream pulse. Successive status reads then walk the acknowledge and busy flags back to idle.

An interrupt-pending flag drives a level interrupt output. The flag is set when the host drops strobe while the printer is selected and interrupts were already enabled. A status read clears it. The pins are sampled into the input latch on every clock, and the direction bit in the control register picks which data copy a data read returns.

Top module: `prn_port_top`

## Requirements
- R1: Only `bus_addr` offsets 0 (data), 1 (status) and 2 (control) are mapped. A read of any other offset returns 0xFF, and a write to any other offset changes no register.
- R2: After reset, `bus_rdata` is 0xFF, `irq` and `out_valid` are 0, status reads 0xF9 (bit 7 not-busy, 6 ack, 5 paper-out, 4 online, 3 not-error, 0 timeout), control reads 0xCC and data reads 0xFF.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and a control read returns that stored value. Control bits: 5 direction (1 = input), 4 interrupt enable, 3 select (active low on the cable), 2 init (active low), 1 auto-feed (active low), 0 strobe.
- R4: A control write with bit 2 clear loads status with 0xD8.
- R5: A control write with bits 2, 3 and 0 all set clears status bit 7. It puts the last data-register write on `out_byte` with a one-cycle `out_valid` pulse only when the previously stored control bit 0 was 0. Without bit 3 set, the write changes no status bit and emits nothing.
- R6: A control write with bits 2 and 3 set and bit 0 clear sets interrupt pending when the previously stored control bit 4 was 1. `irq` follows the pending flag and goes high in the cycle after that write.
- R7: A status read returns the current status and clears interrupt pending. If status bit 7 and control bit 0 are both 0, the read then clears bit 6 when bit 6 was set, and otherwise sets bits 7 and 6.
- R8: A data read returns the pin value latched on the previous clock when control bit 5 is 1, and the last written data byte when it is 0.
- R9: Read data appears on `bus_rdata` one cycle after the read enable and holds until the next read. When `bus_we` and `bus_re` are both high, only the write takes effect: no read side effect occurs and `bus_rdata` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_data | input | 8 | Data lines from the port pins |
| out_byte | output | 8 | Byte passed to the printer model |
| out_valid | output | 1 | One-cycle pulse marking `out_byte` |
| irq | output | 1 | Level interrupt |

## Verification
A host write and a host read can arrive in the same cycle. That matters most when the read is a status read, because a status read clears the interrupt and moves the handshake on. The bench raises both enables at offset 1 while an interrupt is pending. It checks that `irq` stays high and that `bus_rdata` keeps its previous value. It then raises both enables at offset 2 and reads the control register back to confirm that the write landed.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;
  // control bit positions
  localparam int CT_DIR = 5;
  localparam int CT_IEN = 4;
  localparam int CT_SEL = 3;
  localparam int CT_INI = 2;
  localparam int CT_STB = 0;

  localparam logic [BYTE_W-1:0] CTRL_FIXED = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hF9;
  localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [BYTE_W-1:0] IDLE_BYTE  = 8'hFF;

  function automatic logic [BYTE_W-1:0] ctrl_fold(input logic [BYTE_W-1:0] v);
    return v | CTRL_FIXED;
  endfunction

  // status value left behind by a status read
  function automatic logic [BYTE_W-1:0] stat_advance(input logic [BYTE_W-1:0] st,
                                                     input logic stb);
    logic [BYTE_W-1:0] n;
    n = st;
    if (!st[ST_NBUSY] && !stb) begin
      if (st[ST_ACK]) n[ST_ACK] = 1'b0;
      else begin
        n[ST_ACK]   = 1'b1;
        n[ST_NBUSY] = 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/prn_decode.sv
module prn_decode
  import prn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] addr,
  input  logic             we,
  input  logic             re,
  output logic             ev_wr_data,
  output logic             ev_wr_ctrl,
  output logic             ev_rd_data,
  output logic             ev_rd_stat,
  output logic             ev_rd_ctrl,
  output logic             ev_rd_other
);
  logic rd_go;
  assign rd_go = re & ~we;   // write wins

  assign ev_wr_data  = we & (addr == OFF_DATA);
  assign ev_wr_ctrl  = we & (addr == OFF_CTRL);
  assign ev_rd_data  = rd_go & (addr == OFF_DATA);
  assign ev_rd_stat  = rd_go & (addr == OFF_STAT);
  assign ev_rd_ctrl  = rd_go & (addr == OFF_CTRL);
  assign ev_rd_other = rd_go & (addr != OFF_DATA) & (addr != OFF_STAT) & (addr != OFF_CTRL);

  // R9
  decode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_wr_data, ev_wr_ctrl, ev_rd_data, ev_rd_stat, ev_rd_ctrl, ev_rd_other}));
endmodule

// File: rtl/prn_data_path.sv
module prn_data_path
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_wr_data,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] pins,
  input  logic              dir_in,
  output logic [BYTE_W-1:0] data_w,
  output logic [BYTE_W-1:0] data_rd
);
  logic [BYTE_W-1:0] data_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_w <= IDLE_BYTE;
      data_r <= IDLE_BYTE;
    end else begin
      data_r <= pins;
      if (ev_wr_data) data_w <= wdata;
    end
  end

  assign data_rd = dir_in ? data_r : data_w;
endmodule

// File: rtl/prn_handshake.sv
module prn_handshake
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_wr_ctrl,
  input  logic              ev_rd_stat,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] data_w,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic              irq,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid
);
  logic pend_q;
  logic sel_armed;   // init high and select set in written byte
  logic stb_high;    // strobe write while armed
  logic stb_rise;    // strobe went 0 -> 1 while armed
  logic irq_set;

  assign sel_armed = ev_wr_ctrl & wdata[CT_INI] & wdata[CT_SEL];
  assign stb_high  = sel_armed & wdata[CT_STB];
  assign stb_rise  = stb_high & ~ctrl_q[CT_STB];
  assign irq_set   = sel_armed & ~wdata[CT_STB] & ctrl_q[CT_IEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      stat_q    <= STAT_RST;
      pend_q    <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= stb_rise;
      if (stb_rise) out_byte <= data_w;
      if (ev_wr_ctrl) begin
        ctrl_q <= ctrl_fold(wdata);
        if (!wdata[CT_INI]) stat_q <= STAT_INIT;
        else if (stb_high) stat_q[ST_NBUSY] <= 1'b0;
        if (irq_set) pend_q <= 1'b1;
      end else if (ev_rd_stat) begin
        pend_q <= 1'b0;
        stat_q <= stat_advance(stat_q, ctrl_q[CT_STB]);
      end
    end
  end

  assign irq = pend_q;

  // R5
  emit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R5
  emit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(ev_wr_ctrl) && $past(wdata[3:2]) == 2'b11 && $past(wdata[0])
                   && !$past(ctrl_q[0]) && !stat_q[7]));
  // R4
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_ctrl && !wdata[2]) |=> (stat_q == 8'hD8));
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_stat |=> !irq);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ev_wr_ctrl) && $past(ctrl_q[4])));
endmodule

// File: rtl/prn_port_top.sv
module prn_port_top
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] pin_data,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              irq
);
  logic ev_wr_data, ev_wr_ctrl, ev_rd_data, ev_rd_stat, ev_rd_ctrl, ev_rd_other;
  logic [BYTE_W-1:0] ctrl_q, stat_q, data_w, data_rd;

  prn_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .re(bus_re),
    .ev_wr_data(ev_wr_data), .ev_wr_ctrl(ev_wr_ctrl), .ev_rd_data(ev_rd_data),
    .ev_rd_stat(ev_rd_stat), .ev_rd_ctrl(ev_rd_ctrl), .ev_rd_other(ev_rd_other)
  );

  prn_data_path u_dat (
    .clk(clk), .rst_n(rst_n), .ev_wr_data(ev_wr_data), .wdata(bus_wdata),
    .pins(pin_data), .dir_in(ctrl_q[CT_DIR]), .data_w(data_w), .data_rd(data_rd)
  );

  prn_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .ev_wr_ctrl(ev_wr_ctrl), .ev_rd_stat(ev_rd_stat),
    .wdata(bus_wdata), .data_w(data_w), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .irq(irq), .out_byte(out_byte), .out_valid(out_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= IDLE_BYTE;
    else if (ev_rd_data)  bus_rdata <= data_rd;
    else if (ev_rd_stat)  bus_rdata <= stat_q;
    else if (ev_rd_ctrl)  bus_rdata <= ctrl_q;
    else if (ev_rd_other) bus_rdata <= IDLE_BYTE;
  end

  // R1
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_rd_other) |-> (bus_rdata == 8'hFF));
  // R3
  ctrl_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_rd_ctrl) |-> (bus_rdata[7:6] == 2'b11));
  // R9
  hold_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_re || bus_we) |=> $stable(bus_rdata));
endmodule

// File: tb/prn_port_tb.sv
module prn_port_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_wdata = '0, pin_data = '0;
  logic [7:0] bus_rdata, out_byte;
  logic out_valid, irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  prn_port_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_data(pin_data),
    .out_byte(out_byte), .out_valid(out_valid), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic bus_both(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  // entry: {kind(0 write,1 read), addr, value (write data / expected read), pulse expected}
  localparam int NV = 24;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h5A, 1'b0},
    {1'b0, 3'd2, 8'h0C, 1'b0},
    {1'b0, 3'd2, 8'h0D, 1'b1},
    {1'b1, 3'd1, 8'h79, 1'b0},
    {1'b1, 3'd2, 8'hCD, 1'b0},
    {1'b0, 3'd2, 8'h0D, 1'b0},
    {1'b0, 3'd2, 8'h0C, 1'b0},
    {1'b1, 3'd1, 8'h79, 1'b0},
    {1'b1, 3'd1, 8'h39, 1'b0},
    {1'b1, 3'd1, 8'hF9, 1'b0},
    {1'b1, 3'd1, 8'hF9, 1'b0},
    {1'b0, 3'd0, 8'hA5, 1'b0},
    {1'b0, 3'd2, 8'h04, 1'b0},
    {1'b0, 3'd2, 8'h05, 1'b0},
    {1'b1, 3'd1, 8'hF9, 1'b0},
    {1'b0, 3'd2, 8'h04, 1'b0},
    {1'b0, 3'd2, 8'h0D, 1'b1},
    {1'b1, 3'd1, 8'h79, 1'b0},
    {1'b0, 3'd2, 8'h08, 1'b0},
    {1'b1, 3'd1, 8'hD8, 1'b0},
    {1'b1, 3'd2, 8'hC8, 1'b0},
    {1'b1, 3'd1, 8'hD8, 1'b0},
    {1'b1, 3'd0, 8'hA5, 1'b0},
    {1'b1, 3'd5, 8'hFF, 1'b0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] last_wr;
    last_wr = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 rdata", bus_rdata, 8'hFF);
    check("R2 irq", {7'b0, irq}, 8'h00);
    check("R2 out_valid", {7'b0, out_valid}, 8'h00);
    bus_rd(3'd1); check("R2 status", bus_rdata, 8'hF9);
    bus_rd(3'd2); check("R2 control", bus_rdata, 8'hCC);
    bus_rd(3'd0); check("R2 data", bus_rdata, 8'hFF);

    // table walk: R3 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][12] == 1'b0) begin
        bus_wr(VEC[i][11:9], VEC[i][8:1]);
        if (VEC[i][11:9] == 3'd0) last_wr = VEC[i][8:1];
        check("R5 pulse", {7'b0, out_valid}, {7'b0, VEC[i][0]});
        if (VEC[i][0]) check("R5 byte", out_byte, last_wr);
      end else begin
        bus_rd(VEC[i][11:9]);
        check("R7/R3/R4 read", bus_rdata, VEC[i][8:1]);
      end
      @(negedge clk);
      check("R5 pulse end", {7'b0, out_valid}, 8'h00);
    end

    // R6 interrupt
    bus_wr(3'd2, 8'h1C);
    check("R6 no irq when enable was off", {7'b0, irq}, 8'h00);
    bus_wr(3'd2, 8'h1C);
    check("R6 irq set", {7'b0, irq}, 8'h01);
    bus_wr(3'd0, 8'h33);
    check("R6 irq held across data write", {7'b0, irq}, 8'h01);

    // R9 write wins over simultaneous status read
    bus_both(3'd1, 8'h00);
    check("R9 irq not cleared", {7'b0, irq}, 8'h01);
    check("R9 rdata unchanged", bus_rdata, 8'hFF);

    // R7 status read clears pending
    bus_rd(3'd1);
    check("R7 status value", bus_rdata, 8'hD8);
    check("R7 irq cleared", {7'b0, irq}, 8'h00);

    // R8 direction
    pin_data = 8'h3C;
    bus_wr(3'd2, 8'h2C);
    bus_rd(3'd0); check("R8 input latch", bus_rdata, 8'h3C);
    bus_rd(3'd1);
    bus_wr(3'd2, 8'h0C);
    bus_rd(3'd0); check("R8 written copy", bus_rdata, 8'h33);

    // R1 unmapped offsets
    bus_wr(3'd5, 8'h77);
    bus_wr(3'd7, 8'h00);
    bus_rd(3'd7); check("R1 unmapped read", bus_rdata, 8'hFF);
    bus_rd(3'd0); check("R1 data untouched", bus_rdata, 8'h33);
    bus_rd(3'd2); check("R1 control untouched", bus_rdata, 8'hCC);
    bus_rd(3'd1); check("R1 status untouched", bus_rdata, 8'hD8);

    // R9 write wins at control offset; R3 fixed bits
    bus_both(3'd2, 8'h0E);
    bus_rd(3'd2); check("R9 R3 control written", bus_rdata, 8'hCE);
    check("R9 latency hold", bus_rdata, 8'hCE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule